// File: doc/BRIEF.md
# Dual-Level Interrupt Mask and Status Controller

This block gathers interrupt sources for a processor that takes two interrupt levels: an ordinary level with many sources and a fast level with a single source. Each level has a mask of enable bits. The mask is never written directly. Software turns bits on through a set location and turns them off through a clear location, so two agents can change separate bits without a read-modify-write race. Software can read three things for each level: the raw source levels, the sources after masking, and the mask itself. Each level drives one request line to the processor.

On the ordinary level, bit 1 comes from a software-programmed source rather than a pin. Software sets or clears it through a dedicated register and reads it back as bit 1 of the raw status. By default, bit 0 of the ordinary level carries the fast-level source. Software can therefore service the fast source through either level and find it at the same bit position in both. Both request lines are combinational from the registered mask and the source inputs. A write takes effect at the clock edge that samples it.

Register map (byte offsets). The ordinary level is at `IRQ_BASE` (default 0x000) and the fast level at `FIQ_BASE` (default 0x100):
- +0x00: masked request (read-only)
- +0x04: raw source (read-only)
- +0x08: reads the mask; a write sets bits
- +0x0C: a write clears bits (write-only)
- +0x10, ordinary level only: programmed source (write-only)

Top module: `dual_intr_ctrl`

## Requirements
- R1: After reset, every mask bit on both levels is 0, the programmed source is 0, and `irq_o` and `fiq_o` are low.
- R2: A write to +0x08 sets each mask bit whose data bit is 1 and leaves every mask bit whose data bit is 0 unchanged. The new mask reads back at +0x08 after the write's clock edge.
- R3: A write to +0x0C clears each mask bit whose data bit is 1 and leaves every mask bit whose data bit is 0 unchanged.
- R4: Writes to the read-only offsets +0x00 and +0x04 change neither the mask nor any other state.
- R5: A read of +0x04 returns the source levels before masking. Bits at or above the number of implemented sources read 0.
- R6: A read of +0x00 returns the raw sources ANDed with the mask. `irq_o` is the OR of the ordinary-level masked bits, and it follows source changes in the same cycle.
- R7: A write to IRQ +0x10 with data bit 1 high asserts ordinary source bit 1; with data bit 1 low, it deasserts that bit. Data bit 0 has no effect. The pin `irq_src_i[1]` is never used. The programmed value reads back as bit 1 at IRQ +0x04.
- R8: The fast level is one bit wide, in bit 0. `fiq_o` equals `fiq_src_i` AND the fast mask bit. Its mask is independent of the ordinary mask, and its bits 31..1 read 0.
- R9: With `MIRROR_FIQ`=1 (the default), ordinary source bit 0 is `fiq_src_i`, and the pin `irq_src_i[0]` is ignored.
- R10: Reads of the write-only offsets (+0x0C, IRQ +0x10) and of unmapped addresses return 0. `bus_rdata` is 0 whenever no read is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Register access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (12) | Byte address |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data, combinational |
| irq_src_i | input | IRQ_N (32) | Ordinary-level source levels (bits 1 and, when mirrored, 0 unused) |
| fiq_src_i | input | 1 | Fast-level source level |
| irq_o | output | 1 | Ordinary interrupt request to the processor |
| fiq_o | output | 1 | Fast interrupt request to the processor |

## Verification
The hardest condition to reach is an interleaving in which the set and clear locations act on overlapping bit patterns. Between those writes, sources toggle, the programmed source flips, and stray writes land on read-only offsets. A mask bug shows up only when a previously set bit must survive a clear whose data leaves that bit 0.

The bench builds such interleavings by drawing the operation and the data from `$urandom` with a fixed seed. The data are sometimes sparse and sometimes dense, so partial overlaps occur often. After every step, it compares every readable location and both request lines against a bench-side model. Directed cases come first. They cover the values after reset, the ignored data bit 0 of the programmed register, the unused source pins and the isolation between the two masks.

// File: rtl/intc_pkg.sv
package intc_pkg;
   // byte offsets inside one controller window
   localparam int unsigned OFF_REQ  = 'h00;
   localparam int unsigned OFF_RAW  = 'h04;
   localparam int unsigned OFF_EN   = 'h08;
   localparam int unsigned OFF_CLR  = 'h0C;
   localparam int unsigned OFF_SOFT = 'h10;
   // bit of the ordinary level owned by the programmed source
   localparam int unsigned SOFT_BIT = 1;
   // bit of the ordinary level that may mirror the fast source
   localparam int unsigned MIRROR_BIT = 0;

   typedef struct packed {
      logic irq_set;
      logic irq_clr;
      logic fiq_set;
      logic fiq_clr;
      logic soft_wr;
   } intc_wstb_t;
endpackage

// File: rtl/intc_mask_bank.sv
module intc_mask_bank #(
   parameter int unsigned W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         set_we,
   input  logic         clr_we,
   input  logic [W-1:0] wdata,
   input  logic [W-1:0] src,
   output logic [W-1:0] en_o,
   output logic [W-1:0] req_o,
   output logic         any_o
);
   logic [W-1:0] en_q;

   for (genvar b = 0; b < W; b++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            en_q[b] <= 1'b0;
         else if (set_we && wdata[b])
            en_q[b] <= 1'b1;
         else if (clr_we && wdata[b])
            en_q[b] <= 1'b0;
      end
   end

   assign en_o  = en_q;
   assign req_o = src & en_q;
   assign any_o = |req_o;
endmodule

// File: rtl/intc_soft_src.sv
module intc_soft_src (
   input  logic clk,
   input  logic rst_n,
   input  logic we,
   input  logic d,
   output logic q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         q <= 1'b0;
      else if (we)
         q <= d;
   end
endmodule

// File: rtl/intc_regif.sv
module intc_regif
   import intc_pkg::*;
#(
   parameter int unsigned ADDR_W   = 12,
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned IRQ_N    = 32,
   parameter int unsigned IRQ_BASE = 'h000,
   parameter int unsigned FIQ_BASE = 'h100
) (
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [IRQ_N-1:0]  irq_raw,
   input  logic [IRQ_N-1:0]  irq_req,
   input  logic [IRQ_N-1:0]  irq_en,
   input  logic              fiq_raw,
   input  logic              fiq_req,
   input  logic              fiq_en,
   output intc_wstb_t        wstb,
   output logic [DATA_W-1:0] rdata
);
   localparam logic [ADDR_W-1:0] A_IRQ_REQ  = ADDR_W'(IRQ_BASE + OFF_REQ);
   localparam logic [ADDR_W-1:0] A_IRQ_RAW  = ADDR_W'(IRQ_BASE + OFF_RAW);
   localparam logic [ADDR_W-1:0] A_IRQ_EN   = ADDR_W'(IRQ_BASE + OFF_EN);
   localparam logic [ADDR_W-1:0] A_IRQ_CLR  = ADDR_W'(IRQ_BASE + OFF_CLR);
   localparam logic [ADDR_W-1:0] A_IRQ_SOFT = ADDR_W'(IRQ_BASE + OFF_SOFT);
   localparam logic [ADDR_W-1:0] A_FIQ_REQ  = ADDR_W'(FIQ_BASE + OFF_REQ);
   localparam logic [ADDR_W-1:0] A_FIQ_RAW  = ADDR_W'(FIQ_BASE + OFF_RAW);
   localparam logic [ADDR_W-1:0] A_FIQ_EN   = ADDR_W'(FIQ_BASE + OFF_EN);
   localparam logic [ADDR_W-1:0] A_FIQ_CLR  = ADDR_W'(FIQ_BASE + OFF_CLR);

   logic wr_cyc, rd_cyc;
   assign wr_cyc = bus_sel &&  bus_wr;
   assign rd_cyc = bus_sel && !bus_wr;

   always_comb begin
      wstb         = '0;
      wstb.irq_set = wr_cyc && (bus_addr == A_IRQ_EN);
      wstb.irq_clr = wr_cyc && (bus_addr == A_IRQ_CLR);
      wstb.fiq_set = wr_cyc && (bus_addr == A_FIQ_EN);
      wstb.fiq_clr = wr_cyc && (bus_addr == A_FIQ_CLR);
      wstb.soft_wr = wr_cyc && (bus_addr == A_IRQ_SOFT);
   end

   always_comb begin
      rdata = '0;
      if (rd_cyc) begin
         unique case (bus_addr)
            A_IRQ_REQ: rdata = DATA_W'(irq_req);
            A_IRQ_RAW: rdata = DATA_W'(irq_raw);
            A_IRQ_EN:  rdata = DATA_W'(irq_en);
            A_FIQ_REQ: rdata = DATA_W'(fiq_req);
            A_FIQ_RAW: rdata = DATA_W'(fiq_raw);
            A_FIQ_EN:  rdata = DATA_W'(fiq_en);
            default:   rdata = '0;
         endcase
      end
   end
endmodule

// File: rtl/dual_intr_ctrl.sv
module dual_intr_ctrl
   import intc_pkg::*;
#(
   parameter int unsigned ADDR_W     = 12,
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned IRQ_N      = 32,
   parameter int unsigned IRQ_BASE   = 'h000,
   parameter int unsigned FIQ_BASE   = 'h100,
   parameter bit          MIRROR_FIQ = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [IRQ_N-1:0]  irq_src_i,
   input  logic              fiq_src_i,
   output logic              irq_o,
   output logic              fiq_o
);
   localparam int unsigned WIN = OFF_SOFT + 4;

   if (IRQ_N < 2 || IRQ_N > DATA_W) begin : g_bad_n
      $error("IRQ_N must be in 2..DATA_W");
   end
   if ((1 << ADDR_W) < FIQ_BASE + WIN || (1 << ADDR_W) < IRQ_BASE + WIN) begin : g_bad_a
      $error("ADDR_W too small for the register windows");
   end
   if (FIQ_BASE < IRQ_BASE + WIN && IRQ_BASE < FIQ_BASE + WIN) begin : g_bad_ov
      $error("controller windows overlap");
   end

   intc_wstb_t        wstb;
   logic [IRQ_N-1:0]  irq_raw, irq_req, irq_en_q;
   logic              fiq_req, fiq_en_q, soft_q;

   // effective ordinary-level source vector
   if (MIRROR_FIQ) begin : g_mirror
      assign irq_raw[MIRROR_BIT] = fiq_src_i;
   end else begin : g_pin0
      assign irq_raw[MIRROR_BIT] = irq_src_i[MIRROR_BIT];
   end
   assign irq_raw[SOFT_BIT] = soft_q;
   if (IRQ_N > 2) begin : g_upper
      assign irq_raw[IRQ_N-1:2] = irq_src_i[IRQ_N-1:2];
   end

   wire unused_ok = ^{bus_wdata, irq_src_i[1:0]};

   intc_regif #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IRQ_N(IRQ_N),
      .IRQ_BASE(IRQ_BASE), .FIQ_BASE(FIQ_BASE)
   ) u_regif (
      .bus_sel (bus_sel),
      .bus_wr  (bus_wr),
      .bus_addr(bus_addr),
      .irq_raw (irq_raw),
      .irq_req (irq_req),
      .irq_en  (irq_en_q),
      .fiq_raw (fiq_src_i),
      .fiq_req (fiq_req),
      .fiq_en  (fiq_en_q),
      .wstb    (wstb),
      .rdata   (bus_rdata)
   );

   intc_mask_bank #(.W(IRQ_N)) u_irq_bank (
      .clk   (clk),
      .rst_n (rst_n),
      .set_we(wstb.irq_set),
      .clr_we(wstb.irq_clr),
      .wdata (bus_wdata[IRQ_N-1:0]),
      .src   (irq_raw),
      .en_o  (irq_en_q),
      .req_o (irq_req),
      .any_o (irq_o)
   );

   intc_mask_bank #(.W(1)) u_fiq_bank (
      .clk   (clk),
      .rst_n (rst_n),
      .set_we(wstb.fiq_set),
      .clr_we(wstb.fiq_clr),
      .wdata (bus_wdata[0]),
      .src   (fiq_src_i),
      .en_o  (fiq_en_q),
      .req_o (fiq_req),
      .any_o (fiq_o)
   );

   intc_soft_src u_soft (
      .clk  (clk),
      .rst_n(rst_n),
      .we   (wstb.soft_wr),
      .d    (bus_wdata[SOFT_BIT]),
      .q    (soft_q)
   );
endmodule

// File: rtl/intc_chk.sv
module intc_chk
   import intc_pkg::*;
#(
   parameter int unsigned ADDR_W   = 12,
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned IRQ_N    = 32,
   parameter int unsigned IRQ_BASE = 'h000,
   parameter int unsigned FIQ_BASE = 'h100
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_sel,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic [IRQ_N-1:0]  irq_en,
   input logic              fiq_en,
   input logic              soft_q,
   input logic              irq_o,
   input logic              fiq_o
);
   logic w_set, w_clr, w_ro, w_soft;
   assign w_set  = bus_sel && bus_wr && bus_addr == ADDR_W'(IRQ_BASE + OFF_EN);
   assign w_clr  = bus_sel && bus_wr && bus_addr == ADDR_W'(IRQ_BASE + OFF_CLR);
   assign w_soft = bus_sel && bus_wr && bus_addr == ADDR_W'(IRQ_BASE + OFF_SOFT);
   assign w_ro   = bus_sel && bus_wr && (bus_addr == ADDR_W'(IRQ_BASE + OFF_REQ) ||
                                         bus_addr == ADDR_W'(IRQ_BASE + OFF_RAW));

   // R1
   reset_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (irq_en == '0) && !fiq_en && !soft_q);

   // R2
   en_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      w_set |=> ((irq_en & $past(bus_wdata[IRQ_N-1:0])) == $past(bus_wdata[IRQ_N-1:0])));

   // R3
   en_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      w_clr |=> ((irq_en & $past(bus_wdata[IRQ_N-1:0])) == '0));

   // R4
   ro_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      w_ro |=> $stable(irq_en) && $stable(soft_q));

   // R6
   irq_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> (irq_en != '0));

   // R7
   soft_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      w_soft |=> soft_q == $past(bus_wdata[SOFT_BIT]));

   // R8
   fiq_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fiq_o |-> fiq_en);
endmodule

bind dual_intr_ctrl intc_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IRQ_N(IRQ_N),
   .IRQ_BASE(IRQ_BASE), .FIQ_BASE(FIQ_BASE)
) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
   .bus_addr(bus_addr), .bus_wdata(bus_wdata), .irq_en(irq_en_q),
   .fiq_en(fiq_en_q), .soft_q(soft_q), .irq_o(irq_o), .fiq_o(fiq_o)
);

// File: tb/dual_intr_ctrl_test.sv
`timescale 1ns/1ps
module dual_intr_ctrl_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0, bus_wr = 1'b0;
   logic [11:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0, bus_rdata;
   logic [31:0] irq_src = '0;
   logic        fiq_src = 1'b0;
   logic        irq_o, fiq_o;

   int n_run = 0, n_fail = 0;
   bit done = 1'b0;

   // bench model
   logic [31:0] m_irq_en = '0;
   logic        m_fiq_en = 1'b0, m_soft = 1'b0;

   always #2.5 clk = ~clk;

   dual_intr_ctrl uut (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .irq_src_i(irq_src), .fiq_src_i(fiq_src), .irq_o(irq_o), .fiq_o(fiq_o)
   );

   function automatic logic [31:0] exp_raw();
      return {irq_src[31:2], m_soft, fiq_src};
   endfunction

   function automatic logic [31:0] exp_req();
      return exp_raw() & m_irq_en;
   endfunction

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(logic [11:0] a, logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
      if (a == 12'h008) m_irq_en |= d;
      if (a == 12'h00C) m_irq_en &= ~d;
      if (a == 12'h108) m_fiq_en |= d[0];
      if (a == 12'h10C) m_fiq_en &= ~d[0];
      if (a == 12'h010) m_soft = d[1];
   endtask

   task automatic rd(logic [11:0] a, output logic [31:0] d);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      #0.5;
      d = bus_rdata;
      bus_sel = 1'b0;
      #0.2;
   endtask

   task automatic check_all();
      logic [31:0] v;
      #0.5;
      check("R10 idle", bus_rdata, 32'h0);
      rd(12'h000, v); check("R6 irq req", v, exp_req());
      rd(12'h004, v); check("R5 R7 R9 irq raw", v, exp_raw());
      rd(12'h008, v); check("R2 R3 irq en", v, m_irq_en);
      rd(12'h00C, v); check("R10 irq clr", v, 32'h0);
      rd(12'h010, v); check("R10 soft", v, 32'h0);
      rd(12'h100, v); check("R8 fiq req", v, {31'h0, fiq_src & m_fiq_en});
      rd(12'h104, v); check("R8 fiq raw", v, {31'h0, fiq_src});
      rd(12'h108, v); check("R8 fiq en", v, {31'h0, m_fiq_en});
      rd(12'h10C, v); check("R10 fiq clr", v, 32'h0);
      rd(12'h014, v); check("R10 unmapped", v, 32'h0);
      check("R6 irq_o", {31'h0, irq_o}, {31'h0, |exp_req()});
      check("R8 fiq_o", {31'h0, fiq_o}, {31'h0, fiq_src & m_fiq_en});
   endtask

   initial begin
      #(5.0 * 150000);
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'd4711));
      irq_src = 32'hFFFF_FFFF; fiq_src = 1'b1;
      repeat (3) @(negedge clk);
      // R1: nothing enabled while sources all high
      check("R1 irq_o", {31'h0, irq_o}, 32'h0);
      check("R1 fiq_o", {31'h0, fiq_o}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      check_all();
      // R7: programmed source, bit 0 of data ignored, pin 1 ignored
      irq_src = 32'h0; fiq_src = 1'b0;
      wr(12'h008, 32'h0000_0002);
      check("R7 soft idle", {31'h0, irq_o}, 32'h0);
      irq_src = 32'h0000_0002;
      #0.5 check("R7 pin1 ignored", {31'h0, irq_o}, 32'h0);
      wr(12'h010, 32'h0000_0002); check_all();
      check("R7 soft on", {31'h0, irq_o}, 32'h1);
      wr(12'h010, 32'h0000_0001); check_all();
      check("R7 bit0 ignored", {31'h0, irq_o}, 32'h0);
      // R9: mirror into bit 0, pin 0 ignored
      wr(12'h008, 32'h0000_0001);
      irq_src = 32'h0000_0001;
      #0.5 check("R9 pin0 ignored", {31'h0, irq_o}, 32'h0);
      fiq_src = 1'b1; check_all();
      check("R9 mirror", {31'h0, irq_o}, 32'h1);
      // R4: writes to read-only offsets
      wr(12'h000, 32'hFFFF_FFFF); wr(12'h004, 32'h0000_0000); check_all();
      // R8: fast mask isolated from ordinary mask
      wr(12'h108, 32'hFFFF_FFFF); check_all();
      wr(12'h00C, 32'hFFFF_FFFF); check_all();
      check("R8 fiq kept", {31'h0, fiq_o}, 32'h1);
      // random interleavings
      for (int i = 0; i < 400; i++) begin
         logic [31:0] d;
         int op;
         d = ($urandom % 2) ? $urandom : ($urandom & $urandom & $urandom);
         op = $urandom % 8;
         irq_src = $urandom; fiq_src = $urandom % 2;
         case (op)
            0, 1: wr(12'h008, d);
            2, 3: wr(12'h00C, d);
            4:    wr(12'h010, d);
            5:    wr(($urandom % 2) ? 12'h108 : 12'h10C, d);
            6:    wr(($urandom % 2) ? 12'h000 : 12'h004, d);
            default: wr(12'h104, d);
         endcase
         check_all();
      end
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule